// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves one virtual address into a physical address by walking a hierarchical page table held in physical memory. A request carries a 32-bit virtual address, the physical base of the context table and a context number. The walker fetches the context-table entry, then follows descriptors down through up to three further tables. Each fetched 32-bit word is classified as a pointer to a deeper table, a leaf translation, or something that ends the walk with a fault.

A leaf can terminate the walk at any of four depths. The depth decides how many low virtual address bits pass straight through into the 36-bit physical result. Memory is reached through a single read port: a valid/ready request phase, then a response strobe that carries data and an error flag after any number of cycles. The result is presented for one cycle together with a done pulse.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. The virtual address, context number and table base are captured then, and later changes on those inputs do not affect the walk in progress.
- R2: A request whose table base is zero finishes on the next cycle with a fault at level 0 and makes no memory read.
- R3: The first read goes to table base + 4 × context number.
- R4: An entry's type is its bits [1:0]: 2'b01 is a descriptor, 2'b10 is a leaf, 2'b00 is invalid and 2'b11 is reserved. Invalid and reserved entries end the walk with a fault.
- R5: A descriptor's next-table address is the entry with bits [3:0] cleared, shifted left by 4 into 36 bits. The next read is that base + 4 × index. The index is virtual address bits [31:24] for table 1, [23:18] for table 2 and [17:12] for table 3. Every read address is word aligned.
- R6: A descriptor fetched from table 3 ends the walk with a fault at level 3.
- R7: The physical address for a leaf found at level 0 is the virtual address zero-extended. For a leaf found in table 1, 2 or 3 it is (entry with bits [7:0] cleared) shifted left by 4, ORed with virtual address bits [23:0], [17:0] or [11:0] respectively.
- R8: On a hit, `walk_level` gives the depth of the leaf: 0 for the context entry, and 1, 2 or 3 for the tables. `walk_leaf` is the leaf word and `walk_page_base` is the leaf with bits [7:0] cleared. On a fault, `walk_level` is the depth of the last read, and the address, leaf and base outputs are zero.
- R9: A read request holds its address until accepted. A response with the error flag set ends the walk with a fault at the level of that read.
- R10: `walk_done` is high for exactly one cycle, with exactly one of `walk_hit` and `walk_fault`. The walker is ready again in the cycle after it.
- R11: A synchronous active-low reset returns the walker to idle, with `walk_done` and `mem_rd_valid` low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 8 | Context number |
| req_tbl_base | input | 36 | Physical base of the context table |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 36 | Physical word address of the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Fetched table entry |
| mem_rsp_err | input | 1 | Read failed |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_hit | output | 1 | Translation found |
| walk_fault | output | 1 | Walk ended without a translation |
| walk_level | output | 2 | Depth at which the walk ended |
| walk_pa | output | 36 | Composed physical address |
| walk_leaf | output | 32 | Leaf entry |
| walk_page_base | output | 32 | Leaf with its low byte cleared |

## Verification
The checker assumes the memory side sends exactly one response strobe per accepted read, and only after that read was accepted. Under that assumption, a response word's type field can be tied directly to the outcome on the next cycle. The bench's responder keeps to this by holding one outstanding read at most. It randomises the ready and response delays only within that rule, and it drops any pending response during reset. Request inputs are scrambled right after acceptance, so capture is observable.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

   typedef enum logic [1:0] {
      ET_INVALID = 2'b00,
      ET_PTD     = 2'b01,
      ET_PTE     = 2'b10,
      ET_RSVD    = 2'b11
   } ent_kind_e;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_ISSUE = 2'd1,
      WS_WAIT  = 2'd2,
      WS_DONE  = 2'd3
   } walk_state_e;

   localparam int unsigned LVL_W    = 2;
   localparam logic [1:0]  LVL_LAST = 2'd3;
   localparam int unsigned PTR_LSB  = 4;   // descriptor pointer field starts here
   localparam int unsigned PN_LSB   = 8;   // leaf page number field starts here
   localparam int unsigned TBL_SH   = 4;   // shift from entry field to physical address

   typedef struct packed {
      logic leaf;
      logic descend;
      logic fault;
   } ent_verdict_t;

endpackage

// File: rtl/pt_entry_classify.sv
module pt_entry_classify
   import pt_walk_pkg::*;
(
   input  logic [1:0]       kind,
   input  logic [LVL_W-1:0] lvl,
   input  logic             bus_err,
   output ent_verdict_t     verdict
);

   always_comb begin
      verdict = '0;
      if (bus_err) begin
         verdict.fault = 1'b1;
      end else begin
         unique case (ent_kind_e'(kind))
            ET_PTE:  verdict.leaf = 1'b1;
            ET_PTD: begin
               if (lvl == LVL_LAST) verdict.fault   = 1'b1;
               else                 verdict.descend = 1'b1;
            end
            default: verdict.fault = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/pt_next_addr.sv
module pt_next_addr
   import pt_walk_pkg::*;
#(
   parameter int unsigned VA_W   = 32,
   parameter int unsigned ENT_W  = 32,
   parameter int unsigned PA_W   = 36,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX1_W = 8,
   parameter int unsigned IDX2_W = 6,
   parameter int unsigned IDX3_W = 6
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [VA_W-1:0]  va,
   input  logic [LVL_W-1:0] tgt_lvl,
   output logic [PA_W-1:0]  addr
);

   localparam int unsigned SH3 = OFF_W;
   localparam int unsigned SH2 = SH3 + IDX3_W;
   localparam int unsigned SH1 = SH2 + IDX2_W;
   localparam logic [ENT_W-1:0] PTR_MASK = ~((ENT_W'(1) << PTR_LSB) - ENT_W'(1));
   localparam logic [PA_W-1:0]  M1 = (PA_W'(1) << IDX1_W) - PA_W'(1);
   localparam logic [PA_W-1:0]  M2 = (PA_W'(1) << IDX2_W) - PA_W'(1);
   localparam logic [PA_W-1:0]  M3 = (PA_W'(1) << IDX3_W) - PA_W'(1);

   logic [PA_W-1:0] tbl_base;
   logic [PA_W-1:0] va_ext;
   logic [PA_W-1:0] idx_ext;

   assign tbl_base = PA_W'(entry & PTR_MASK) << TBL_SH;
   assign va_ext   = PA_W'(va);

   always_comb begin
      unique case (tgt_lvl)
         2'd1:    idx_ext = (va_ext >> SH1) & M1;
         2'd2:    idx_ext = (va_ext >> SH2) & M2;
         default: idx_ext = (va_ext >> SH3) & M3;
      endcase
   end

   assign addr = tbl_base + (idx_ext << 2);

endmodule

// File: rtl/pt_pa_compose.sv
module pt_pa_compose
   import pt_walk_pkg::*;
#(
   parameter int unsigned VA_W   = 32,
   parameter int unsigned ENT_W  = 32,
   parameter int unsigned PA_W   = 36,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX2_W = 6,
   parameter int unsigned IDX3_W = 6
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [VA_W-1:0]  va,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  pa,
   output logic [ENT_W-1:0] page_base
);

   localparam int unsigned N_LVL = 1 << LVL_W;
   localparam int unsigned SH3   = OFF_W;
   localparam int unsigned SH2   = SH3 + IDX3_W;
   localparam int unsigned SH1   = SH2 + IDX2_W;
   localparam int unsigned KEEP_W [N_LVL] = '{VA_W, SH1, SH2, SH3};
   localparam logic [ENT_W-1:0] PN_MASK = ~((ENT_W'(1) << PN_LSB) - ENT_W'(1));

   logic [PA_W-1:0] page_pa;
   logic [PA_W-1:0] cand [N_LVL];

   assign page_base = entry & PN_MASK;
   assign page_pa   = PA_W'(page_base) << TBL_SH;

   for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
      if (g == 0) begin : g_ctx
         assign cand[g] = PA_W'(va);
      end else begin : g_tbl
         localparam logic [PA_W-1:0] KEEP_M = (PA_W'(1) << KEEP_W[g]) - PA_W'(1);
         assign cand[g] = page_pa | (PA_W'(va) & KEEP_M);
      end
   end

   assign pa = cand[lvl];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int unsigned VA_W   = 32,
   parameter int unsigned PA_W   = 36,
   parameter int unsigned ENT_W  = 32,
   parameter int unsigned CTX_W  = 8,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX1_W = 8,
   parameter int unsigned IDX2_W = 6,
   parameter int unsigned IDX3_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [PA_W-1:0]   req_tbl_base,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [PA_W-1:0]   mem_rd_addr,
   input  logic              mem_rsp_valid,
   input  logic [ENT_W-1:0]  mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              walk_done,
   output logic              walk_hit,
   output logic              walk_fault,
   output logic [LVL_W-1:0]  walk_level,
   output logic [PA_W-1:0]   walk_pa,
   output logic [ENT_W-1:0]  walk_leaf,
   output logic [ENT_W-1:0]  walk_page_base
);

   if (VA_W != OFF_W + IDX1_W + IDX2_W + IDX3_W) begin : g_bad_split
      $error("pt_walker: offset and index widths must sum to VA_W");
   end
   if (PA_W != ENT_W + TBL_SH) begin : g_bad_pa
      $error("pt_walker: PA_W must equal ENT_W + TBL_SH");
   end
   if (CTX_W + 2 > PA_W) begin : g_bad_ctx
      $error("pt_walker: context number too wide for the address");
   end
   if (ENT_W <= PN_LSB) begin : g_bad_ent
      $error("pt_walker: entry too narrow for a page number");
   end

   walk_state_e       state_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [PA_W-1:0]   addr_q;
   logic [VA_W-1:0]   va_q;
   logic              hit_q, fault_q;
   logic [PA_W-1:0]   pa_q;
   logic [ENT_W-1:0]  leaf_q, base_q;

   ent_verdict_t      verdict;
   logic [PA_W-1:0]   nxt_addr;
   logic [PA_W-1:0]   cmp_pa;
   logic [ENT_W-1:0]  cmp_base;
   logic [LVL_W-1:0]  lvl_inc;

   assign lvl_inc = lvl_q + LVL_W'(1);

   pt_entry_classify u_classify (
      .kind    (mem_rsp_data[1:0]),
      .lvl     (lvl_q),
      .bus_err (mem_rsp_err),
      .verdict (verdict)
   );

   pt_next_addr #(
      .VA_W (VA_W), .ENT_W (ENT_W), .PA_W (PA_W), .OFF_W (OFF_W),
      .IDX1_W (IDX1_W), .IDX2_W (IDX2_W), .IDX3_W (IDX3_W)
   ) u_next (
      .entry   (mem_rsp_data),
      .va      (va_q),
      .tgt_lvl (lvl_inc),
      .addr    (nxt_addr)
   );

   pt_pa_compose #(
      .VA_W (VA_W), .ENT_W (ENT_W), .PA_W (PA_W), .OFF_W (OFF_W),
      .IDX2_W (IDX2_W), .IDX3_W (IDX3_W)
   ) u_compose (
      .entry     (mem_rsp_data),
      .va        (va_q),
      .lvl       (lvl_q),
      .pa        (cmp_pa),
      .page_base (cmp_base)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         lvl_q   <= '0;
         addr_q  <= '0;
         va_q    <= '0;
         hit_q   <= 1'b0;
         fault_q <= 1'b0;
         pa_q    <= '0;
         leaf_q  <= '0;
         base_q  <= '0;
      end else begin
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  lvl_q   <= '0;
                  hit_q   <= 1'b0;
                  fault_q <= 1'b0;
                  pa_q    <= '0;
                  leaf_q  <= '0;
                  base_q  <= '0;
                  if (req_tbl_base == '0) begin
                     fault_q <= 1'b1;
                     state_q <= WS_DONE;
                  end else begin
                     addr_q  <= req_tbl_base + (PA_W'(req_ctx) << 2);
                     state_q <= WS_ISSUE;
                  end
               end
            end
            WS_ISSUE: begin
               if (mem_rd_ready) state_q <= WS_WAIT;
            end
            WS_WAIT: begin
               if (mem_rsp_valid) begin
                  if (verdict.leaf) begin
                     hit_q   <= 1'b1;
                     leaf_q  <= mem_rsp_data;
                     pa_q    <= cmp_pa;
                     base_q  <= cmp_base;
                     state_q <= WS_DONE;
                  end else if (verdict.descend) begin
                     addr_q  <= nxt_addr;
                     lvl_q   <= lvl_inc;
                     state_q <= WS_ISSUE;
                  end else begin
                     fault_q <= 1'b1;
                     state_q <= WS_DONE;
                  end
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == WS_IDLE);
   assign mem_rd_valid   = (state_q == WS_ISSUE);
   assign mem_rd_addr    = addr_q;
   assign walk_done      = (state_q == WS_DONE);
   assign walk_hit       = hit_q;
   assign walk_fault     = fault_q;
   assign walk_level     = lvl_q;
   assign walk_pa        = pa_q;
   assign walk_leaf      = leaf_q;
   assign walk_page_base = base_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int unsigned PA_W  = 36,
   parameter int unsigned ENT_W = 32,
   parameter int unsigned CTX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [CTX_W-1:0] req_ctx,
   input logic [PA_W-1:0]  req_tbl_base,
   input logic             mem_rd_valid,
   input logic             mem_rd_ready,
   input logic [PA_W-1:0]  mem_rd_addr,
   input logic             mem_rsp_valid,
   input logic [ENT_W-1:0] mem_rsp_data,
   input logic             mem_rsp_err,
   input logic             walk_done,
   input logic             walk_hit,
   input logic             walk_fault,
   input logic [ENT_W-1:0] walk_leaf
);

   // R1: busy walker never advertises ready
   p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || walk_done) |-> !req_ready);

   // R2: zero base faults at once without a read
   p_zero_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_tbl_base == '0)
      |=> (walk_done && walk_fault && !mem_rd_valid));

   // R3: first read address
   p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_tbl_base != '0)
      |=> (mem_rd_valid &&
           mem_rd_addr == $past(req_tbl_base + (PA_W'(req_ctx) << 2))));

   // R4: invalid or reserved type ends the walk with a fault
   p_bad_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && !mem_rsp_err &&
       (mem_rsp_data[1:0] == 2'b00 || mem_rsp_data[1:0] == 2'b11))
      |=> (walk_done && walk_fault));

   // R8: leaf type ends the walk with a hit carrying the entry
   p_leaf_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && !mem_rsp_err && mem_rsp_data[1:0] == 2'b10)
      |=> (walk_done && walk_hit && walk_leaf == $past(mem_rsp_data)));

   // R5: reads are word aligned
   p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

   // R9: request held until accepted
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R9: error response ends with a fault
   p_err_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && mem_rsp_err) |=> (walk_done && walk_fault));

   // R10: done is a single-cycle pulse followed by idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> (!walk_done && req_ready));

   // R10: exactly one outcome flag with done
   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> (walk_hit != walk_fault));

endmodule

bind pt_walker pt_walker_chk #(
   .PA_W (PA_W), .ENT_W (ENT_W), .CTX_W (CTX_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_ctx       (req_ctx),
   .req_tbl_base  (req_tbl_base),
   .mem_rd_valid  (mem_rd_valid),
   .mem_rd_ready  (mem_rd_ready),
   .mem_rd_addr   (mem_rd_addr),
   .mem_rsp_valid (mem_rsp_valid),
   .mem_rsp_data  (mem_rsp_data),
   .mem_rsp_err   (mem_rsp_err),
   .walk_done     (walk_done),
   .walk_hit      (walk_hit),
   .walk_fault    (walk_fault),
   .walk_leaf     (walk_leaf)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [7:0]  req_ctx;
   logic [35:0] req_tbl_base;
   logic        mem_rd_valid;
   logic        mem_rd_ready;
   logic [35:0] mem_rd_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        mem_rsp_err;
   logic        walk_done, walk_hit, walk_fault;
   logic [1:0]  walk_level;
   logic [35:0] walk_pa;
   logic [31:0] walk_leaf, walk_page_base;

   always #10 clk = ~clk;   // 50 MHz

   pt_walker u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
      .req_ctx (req_ctx), .req_tbl_base (req_tbl_base),
      .mem_rd_valid (mem_rd_valid), .mem_rd_ready (mem_rd_ready),
      .mem_rd_addr (mem_rd_addr), .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data), .mem_rsp_err (mem_rsp_err),
      .walk_done (walk_done), .walk_hit (walk_hit), .walk_fault (walk_fault),
      .walk_level (walk_level), .walk_pa (walk_pa), .walk_leaf (walk_leaf),
      .walk_page_base (walk_page_base)
   );

   logic [31:0] bmem [0:1023];
   int          nchk = 0;
   int          nfail = 0;
   bit          finished = 0;
   bit          err_en = 0;
   logic [35:0] err_addr = '0;
   int          nreads;
   bit          addr_bad;
   int          seed = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   // memory responder: one outstanding read, pseudo-random latencies
   initial begin
      bit          pending = 0;
      int          dly = 0;
      logic [35:0] paddr = '0;
      mem_rd_ready  = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      mem_rsp_err   = 1'b0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_rsp_err   = 1'b0;
         if (!rst_n) begin
            pending      = 0;
            mem_rd_ready = 1'b0;
         end else if (pending) begin
            mem_rd_ready = 1'b0;
            if (dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = bmem[paddr[11:2]];
               mem_rsp_err   = err_en && (paddr == err_addr);
               pending       = 0;
            end else begin
               dly--;
            end
         end else begin
            seed++;
            mem_rd_ready = (seed % 3) != 0;
            if (mem_rd_valid && mem_rd_ready) begin
               pending = 1;
               paddr   = mem_rd_addr;
               dly     = (seed * 7) % 3;
               nreads++;
               if (mem_rd_addr[35:12] != '0) addr_bad = 1;
            end
         end
      end
   end

   // independent reference of the walk, from the requirements
   function automatic void ref_walk(input logic [31:0] va, input logic [7:0] ctx,
                                    input logic [35:0] base,
                                    output logic e_hit, output logic [1:0] e_lvl,
                                    output logic [35:0] e_pa, output logic [31:0] e_leaf,
                                    output int e_reads);
      logic [35:0] a;
      logic [35:0] idx;
      logic [31:0] e;
      bit          stop;
      e_hit = 0; e_lvl = 0; e_pa = '0; e_leaf = '0; e_reads = 0;
      if (base == '0) return;
      a    = base + {26'd0, ctx, 2'b00};
      stop = 0;
      for (int l = 0; l < 4 && !stop; l++) begin
         e = bmem[a[11:2]];
         e_reads++;
         e_lvl = 2'(l);
         if (err_en && a == err_addr) begin
            stop = 1;
         end else if (e[1:0] == 2'b10) begin
            e_hit  = 1;
            e_leaf = e;
            case (l)
               0:       e_pa = {4'h0, va};
               1:       e_pa = {e[31:8], 12'h0} | {12'h0, va[23:0]};
               2:       e_pa = {e[31:8], 12'h0} | {18'h0, va[17:0]};
               default: e_pa = {e[31:8], 12'h0} | {24'h0, va[11:0]};
            endcase
            stop = 1;
         end else if (e[1:0] == 2'b01 && l < 3) begin
            case (l)
               0:       idx = 36'(va[31:24]);
               1:       idx = 36'(va[23:18]);
               default: idx = 36'(va[17:12]);
            endcase
            a = {e[31:4], 8'h00} + idx * 4;
         end else begin
            stop = 1;
         end
      end
   endfunction

   task automatic build_tables();
      for (int w = 0; w < 1024; w++) bmem[w] = '0;
      // context table at 0x100
      bmem[10'h040] = 32'hABCDE1F6;          // leaf at context level
      bmem[10'h041] = 32'h0000004D;          // descriptor -> 0x400
      bmem[10'h042] = 32'hFFFFFF00;          // invalid
      bmem[10'h043] = 32'h12345673;          // reserved
      // second context table at 0xA00, context 5 -> 0x400
      bmem[10'h285] = 32'h00000041;
      // table 1 at 0x400
      for (int i = 0; i < 256; i++) begin
         case (i % 4)
            0: bmem[10'h100 + i] = {24'h5A5A5A ^ (24'(i) * 24'h010101), 8'h3E};
            1: bmem[10'h100 + i] = 32'h0000008D;   // -> 0x800
            2: bmem[10'h100 + i] = 32'(i) << 8;
            default: bmem[10'h100 + i] = (32'(i) << 8) | 32'h3;
         endcase
      end
      // table 2 at 0x800
      for (int j = 0; j < 64; j++) begin
         case (j % 4)
            0: bmem[10'h200 + j] = {24'h3C0000 + 24'(j) * 24'h1357, 8'hA6};
            1: bmem[10'h200 + j] = 32'h00000095;   // -> 0x900
            2: bmem[10'h200 + j] = 32'h00000000;
            default: bmem[10'h200 + j] = {24'hF00000 | 24'(j), 8'h02};
         endcase
      end
      // table 3 at 0x900
      for (int k = 0; k < 64; k++) begin
         case (k % 3)
            0: bmem[10'h240 + k] = {24'h900000 + 24'(k) * 24'h0B1, 8'hEE};
            1: bmem[10'h240 + k] = 32'h000000A1;   // descriptor in last table
            default: bmem[10'h240 + k] = 32'h00000000;
         endcase
      end
   endtask

   task automatic run_walk(input logic [31:0] va, input logic [7:0] ctx,
                           input logic [35:0] base);
      logic        e_hit;
      logic [1:0]  e_lvl;
      logic [35:0] e_pa;
      logic [31:0] e_leaf;
      int          e_reads;
      int          cyc;
      bit          ready_bad;
      ref_walk(va, ctx, base, e_hit, e_lvl, e_pa, e_leaf, e_reads);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      nreads = 0; addr_bad = 0; ready_bad = 0;
      req_valid = 1'b1; req_vaddr = va; req_ctx = ctx; req_tbl_base = base;
      @(negedge clk);
      // R1: scramble request inputs after acceptance
      req_valid = 1'b0; req_vaddr = ~va; req_ctx = ctx + 8'd1; req_tbl_base = 36'h0FFC;
      cyc = 0;
      while (!walk_done && cyc < 200) begin
         if (req_ready) ready_bad = 1;
         @(negedge clk);
         cyc++;
      end
      chk(walk_done, "R10", "done seen", 64'(walk_done), 64'd1);
      chk(!ready_bad, "R1", "ready low while busy", 64'(ready_bad), 64'd0);
      chk(walk_hit == e_hit && walk_fault == !e_hit, "R4", "outcome",
          {walk_hit, walk_fault}, {e_hit, !e_hit});
      chk(walk_level == e_lvl, "R8", "level", 64'(walk_level), 64'(e_lvl));
      chk(walk_pa == e_pa, "R7", "physical address", 64'(walk_pa), 64'(e_pa));
      chk(walk_leaf == e_leaf, "R8", "leaf", 64'(walk_leaf), 64'(e_leaf));
      chk(walk_page_base == {e_leaf[31:8], 8'h00}, "R8", "page base",
          64'(walk_page_base), 64'({e_leaf[31:8], 8'h00}));
      chk(nreads == e_reads && !addr_bad, "R5", "read count", 64'(nreads), 64'(e_reads));
      @(negedge clk);
      chk(!walk_done && req_ready, "R10", "single pulse then idle",
          {walk_done, req_ready}, 64'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_ctx = '0; req_tbl_base = '0;
      build_tables();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk(req_ready && !walk_done && !mem_rd_valid, "R11", "reset state",
          {req_ready, walk_done, mem_rd_valid}, 64'b100);

      // R2: zero table base
      run_walk(32'h12345678, 8'd1, 36'h0);
      // context-level leaf, invalid, reserved (R4, R7)
      run_walk(32'hDEADBEEF, 8'd0, 36'h100);
      run_walk(32'h01020304, 8'd2, 36'h100);
      run_walk(32'h01020304, 8'd3, 36'h100);
      // R3: other base and larger context
      run_walk(32'h01040ABC, 8'd5, 36'hA00);
      run_walk(32'h00000000, 8'd5, 36'hA00);
      // sweep of table 1 index (R5, R6, R7)
      for (int i = 0; i < 256; i++)
         run_walk({8'(i), 6'((i >> 2) & 63), 6'((i * 11) & 63), 12'((i * 37) & 12'hFFF)},
                  8'd1, 36'h100);
      // sweep of table 2 index
      for (int j = 0; j < 64; j++)
         run_walk({8'd1, 6'(j), 6'((j * 3) & 63), 12'(j * 61)}, 8'd1, 36'h100);
      // sweep of table 3 index, including the descriptor-in-last-table fault (R6)
      for (int k = 0; k < 64; k++)
         run_walk({8'd1, 6'd1, 6'(k), 12'hFFF - 12'(k)}, 8'd1, 36'h100);

      // R9: error responses at levels 0 and 2
      err_en = 1; err_addr = 36'h104;
      run_walk(32'h01050123, 8'd1, 36'h100);
      err_addr = 36'h804;
      run_walk(32'h01050123, 8'd1, 36'h100);
      err_en = 0;

      // R11: reset during a walk
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h01050123; req_ctx = 8'd1; req_tbl_base = 36'h100;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(req_ready && !walk_done && !mem_rd_valid, "R11", "reset mid-walk",
          {req_ready, walk_done, mem_rd_valid}, 64'b100);
      rst_n = 1'b1;
      run_walk(32'h01050123, 8'd1, 36'h100);

      finish_run();
   end

endmodule